// File: doc/BRIEF.md
# Programmable SCL Clock Generator

This block produces the serial clock for a bus master from a fast system clock. An 8-bit configuration word sets the clock. A divider code and a speed-mode bit fix the length of the high and low phases. A separate enable adds a ninth acknowledge pulse after the eight data pulses of each byte. One more bit is held only for the data-line logic next to this block.

A transfer controller pulses `start` to clock out one byte. The block answers with a strobe at the end of every high phase and a one-cycle `done` when the byte's last pulse ends. A `stop` pulse abandons the byte at once. Writing the configuration while a byte is in flight also abandons it, and that loss is reported. Divider codes below 3 are refused: the error flag rises and SCL stays high.

Top module: `scl_clkgen`

## Requirements
- R1: After reset `scl_o` is 1, `busy`, `done`, `bit_strobe` and `xfer_lost` are 0. The configuration word is 0, so `cfg_err` is 1.
- R2: Standard mode (`cfg_wdata[5]`=0) with divider code C (`cfg_wdata[4:0]`) gives each SCL pulse a low phase of 4·C and a high phase of 4·C clock cycles.
- R3: Fast mode (`cfg_wdata[5]`=1) with C other than 5 gives a low phase of 2·C and a high phase of 2·C cycles.
- R4: Fast mode with C = 5 gives a low phase of 6 cycles and a high phase of 4 cycles, a period of 10.
- R5: A byte has 8 pulses when `cfg_wdata[7]`=0 and 9 pulses when it is 1. `ack_phase` is 1 through both phases of the ninth pulse and is 0 otherwise.
- R6: SCL goes low in the cycle after an accepted `start`. `bit_strobe` pulses once after each high phase. After the last high phase, `done` pulses for one cycle, `busy` falls at the same time, and SCL stays high while idle.
- R7: With C in 0..2, `cfg_err` is 1 and `start` is ignored: `busy` stays 0 and SCL stays 1.
- R8: A configuration write while `busy` ends the byte in the next cycle. SCL goes high, `xfer_lost` pulses for one cycle, no `done` is given, and the new word takes effect. A write while idle gives no `xfer_lost`.
- R9: `stop` while busy returns the block to idle in the next cycle with SCL high and no `done`.
- R10: `start` is ignored while busy, and also in a cycle that carries a configuration write.
- R11: `ack_nret` follows bit 6 of the last word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word: [4:0] divider code, [5] fast mode, [6] no-ack level, [7] ninth-pulse enable |
| start | input | 1 | Begin one byte of clocking |
| stop | input | 1 | Abandon the current byte |
| scl_o | output | 1 | Serial clock output |
| busy | output | 1 | A byte is being clocked |
| bit_strobe | output | 1 | One-cycle pulse after each high phase |
| ack_phase | output | 1 | The ninth pulse is in progress |
| done | output | 1 | One-cycle pulse after the last high phase |
| cfg_err | output | 1 | Divider code is illegal |
| xfer_lost | output | 1 | One-cycle pulse when a write abandoned a byte |
| ack_nret | output | 1 | Stored no-ack level for the data-line logic |

## Verification
The hardest case is a start request, a configuration write or a stop that arrives part-way through a phase. The bench gets there by counting sampled cycles inside its measuring loop. It pulses `start` in the middle of a running byte, and it writes or stops a set number of cycles after a byte begins. After each of these it measures the next byte in full, so any damage left in the phase timer shows up as a wrong phase length. Beyond that, the bench sweeps every divider code in both modes and measures every phase of every pulse against lengths it computes itself.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int CODE_W       = 5;
  localparam int CFG_W        = 8;
  localparam int CNT_W        = CODE_W + 3;
  localparam int MIN_CODE     = 3;
  localparam int SPECIAL_CODE = 5;
  localparam int SPECIAL_HIGH = 4;
  localparam int SPECIAL_LOW  = 6;
  localparam int STD_HALF_MUL = 4;
  localparam int FAST_HALF_MUL = 2;

  typedef struct packed {
    logic              ack_clk;
    logic              ack_nret;
    logic              fast;
    logic [CODE_W-1:0] code;
  } cfg_t;

  function automatic logic code_legal(input logic [CODE_W-1:0] code);
    return code >= CODE_W'(MIN_CODE);
  endfunction

  // Length of one SCL phase in system clock cycles.
  function automatic logic [CNT_W-1:0] half_len(input logic [CODE_W-1:0] code,
                                                input logic fast,
                                                input logic high);
    logic [CNT_W-1:0] c;
    c = CNT_W'(code);
    if (fast && code == CODE_W'(SPECIAL_CODE))
      return high ? CNT_W'(SPECIAL_HIGH) : CNT_W'(SPECIAL_LOW);
    else if (fast)
      return c * CNT_W'(FAST_HALF_MUL);
    else
      return c * CNT_W'(STD_HALF_MUL);
  endfunction
endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg
  import scl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             busy,
  output cfg_t             cfg,
  output logic             err,
  output logic             lost
);
  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      lost  <= 1'b0;
    end else begin
      lost <= we && busy;
      if (we) cfg_q <= cfg_t'(wdata);
    end
  end

  assign cfg = cfg_q;
  assign err = !code_legal(cfg_q.code);
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val - CNT_W'(1);
    else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/scl_bit_seq.sv
module scl_bit_seq
  import scl_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic              kill,
  input  logic              expire,
  input  logic [CODE_W-1:0] code,
  input  logic              fast,
  input  logic              ack_clk,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              scl_q,
  output logic              busy,
  output logic              done,
  output logic              bit_strobe,
  output logic              ack_phase
);
  localparam int BIT_W = $clog2(DATA_BITS + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_t;
  state_t st;
  logic [BIT_W-1:0] bit_idx;
  logic [BIT_W-1:0] last_idx;
  logic             at_last;

  assign last_idx = ack_clk ? BIT_W'(DATA_BITS) : BIT_W'(DATA_BITS - 1);
  assign at_last  = (bit_idx == last_idx);

  always_comb begin
    load     = 1'b0;
    load_val = half_len(code, fast, 1'b0);
    if (!kill) begin
      case (st)
        S_IDLE:  load = start_ok;
        S_LOW: begin
          load     = expire;
          load_val = half_len(code, fast, 1'b1);
        end
        S_HIGH:  load = expire && !at_last;
        default: load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      bit_idx    <= '0;
      scl_q      <= 1'b1;
      done       <= 1'b0;
      bit_strobe <= 1'b0;
    end else begin
      done       <= 1'b0;
      bit_strobe <= 1'b0;
      if (kill) begin
        st    <= S_IDLE;
        scl_q <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (start_ok) begin
            st      <= S_LOW;
            scl_q   <= 1'b0;
            bit_idx <= '0;
          end
          S_LOW: if (expire) begin
            st    <= S_HIGH;
            scl_q <= 1'b1;
          end
          S_HIGH: if (expire) begin
            bit_strobe <= 1'b1;
            if (at_last) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st      <= S_LOW;
              scl_q   <= 1'b0;
              bit_idx <= bit_idx + BIT_W'(1);
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign busy      = (st != S_IDLE);
  assign ack_phase = busy && (bit_idx == BIT_W'(DATA_BITS));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             start,
  input  logic             stop,
  output logic             scl_o,
  output logic             busy,
  output logic             bit_strobe,
  output logic             ack_phase,
  output logic             done,
  output logic             cfg_err,
  output logic             xfer_lost,
  output logic             ack_nret
);
  cfg_t             cfg;
  logic             start_ok;
  logic             kill;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expire;

  scl_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .busy  (busy),
    .cfg   (cfg),
    .err   (cfg_err),
    .lost  (xfer_lost)
  );

  // A write or a stop pulse abandons the byte; a write cycle never starts one.
  assign kill     = cfg_we || stop;
  assign start_ok = start && !cfg_we && !cfg_err;

  scl_phase_timer u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  scl_bit_seq #(.DATA_BITS(DATA_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ok   (start_ok),
    .kill       (kill),
    .expire     (tmr_expire),
    .code       (cfg.code),
    .fast       (cfg.fast),
    .ack_clk    (cfg.ack_clk),
    .load       (tmr_load),
    .load_val   (tmr_val),
    .scl_q      (scl_o),
    .busy       (busy),
    .done       (done),
    .bit_strobe (bit_strobe),
    .ack_phase  (ack_phase)
  );

  assign ack_nret = cfg.ack_nret;
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic start,
  input logic stop,
  input logic scl_o,
  input logic busy,
  input logic bit_strobe,
  input logic done,
  input logic cfg_err,
  input logic xfer_lost
);
  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> scl_o);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && scl_o) ##1 !done);

  // R6
  strobe_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> $past(scl_o && busy));

  // R7
  illegal_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_err && !busy) |=> !busy);

  // R8
  write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we) |=> (xfer_lost && !busy && scl_o && !done));

  // R8
  lost_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_lost |-> $past(busy && cfg_we));

  // R9
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop) |=> (!busy && !done && scl_o));
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .start      (start),
  .stop       (stop),
  .scl_o      (scl_o),
  .busy       (busy),
  .bit_strobe (bit_strobe),
  .done       (done),
  .cfg_err    (cfg_err),
  .xfer_lost  (xfer_lost)
);

// File: tb/scl_clkgen_test.sv
module scl_clkgen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic scl_o, busy, bit_strobe, ack_phase, done, cfg_err, xfer_lost, ack_nret;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_clkgen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .start(start), .stop(stop), .scl_o(scl_o), .busy(busy),
    .bit_strobe(bit_strobe), .ack_phase(ack_phase), .done(done),
    .cfg_err(cfg_err), .xfer_lost(xfer_lost), .ack_nret(ack_nret)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_high(input int c, input bit fast);
    int p;
    p = fast ? ((c == 5) ? 10 : 4 * c) : 8 * c;
    return (fast && c == 5) ? 4 : p / 2;
  endfunction

  function automatic int exp_low(input int c, input bit fast);
    int p;
    p = fast ? ((c == 5) ? 10 : 4 * c) : 8 * c;
    return p - exp_high(c, fast);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic write_cfg(input logic [7:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Starts a byte and measures every phase. poke > 0 pulses start again
  // at that sampled cycle of the byte (R10).
  task automatic run_xfer(input int c, input bit fast, input bit ack, input int poke,
                          input string req);
    int lo, hi, pulses, strobes, ackc, run, g;
    bit cur, bad;
    lo = exp_low(c, fast); hi = exp_high(c, fast);
    pulses = 0; strobes = 0; ackc = 0; run = 0; g = 0; cur = 1'b0; bad = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !scl_o, "R6 start", int'(busy), 1);
    while (busy && g < 6000) begin
      if (scl_o != cur) begin
        if (!cur && run != lo) bad = 1'b1;
        if (cur) begin
          if (run != hi) bad = 1'b1;
          pulses++;
        end
        cur = scl_o; run = 0;
      end
      run++;
      if (bit_strobe) strobes++;
      if (ack_phase) ackc++;
      g++;
      start = (g == poke);
      @(negedge clk);
    end
    start = 1'b0;
    if (cur && run == hi) pulses++; else bad = 1'b1;
    if (bit_strobe) strobes++;
    check(!bad, req, run, hi);
    check(pulses == (ack ? 9 : 8) && strobes == pulses, "R5 R6 pulse count",
          pulses, ack ? 9 : 8);
    check(ackc == (ack ? lo + hi : 0), "R5 ack_phase", ackc, ack ? lo + hi : 0);
    check(done && scl_o, "R6 done", int'(done), 1);
    @(negedge clk);
    check(!done && !busy && scl_o, "R6 idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scl_o && !busy && !done && !bit_strobe && !xfer_lost && cfg_err,
          "R1 reset", int'(scl_o), 1);
    rst_n = 1'b1;

    // R2 R3 R4 sweep of every legal code in both modes
    for (int m = 0; m < 2; m++) begin
      for (int c = 3; c < 32; c++) begin
        bit ack;
        ack = c[0];
        write_cfg({ack, 1'b0, m[0], c[4:0]});
        check(!cfg_err, "R7 legal code", int'(cfg_err), 0);
        run_xfer(c, m[0], ack, 0, (m == 0) ? "R2 std phase" :
                 ((c == 5) ? "R4 fast special" : "R3 fast phase"));
      end
    end

    // R7 illegal codes
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 3; c++) begin
        write_cfg({2'b10, m[0], c[4:0]});
        check(cfg_err, "R7 err flag", int'(cfg_err), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && scl_o, "R7 start ignored", int'(busy), 0);
      end
    end

    // R11
    write_cfg(8'h4A);
    check(ack_nret == 1'b1, "R11 ack_nret set", int'(ack_nret), 1);
    write_cfg(8'h0A);
    check(ack_nret == 1'b0, "R11 ack_nret clear", int'(ack_nret), 0);
    check(!xfer_lost, "R8 idle write no loss", int'(xfer_lost), 0);

    // R10 start during a byte is ignored
    write_cfg(8'h24);
    run_xfer(4, 1'b1, 1'b0, 13, "R10 restart ignored");

    // R10 start with a write in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'h06; start = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0;
    check(!busy && scl_o, "R10 start on write ignored", int'(busy), 0);

    // R8 write while busy
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (37) @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'hA5;
    @(negedge clk);
    cfg_we = 1'b0;
    check(xfer_lost && !busy && scl_o && !done, "R8 write abort", int'(xfer_lost), 1);
    @(negedge clk);
    check(!xfer_lost && !done, "R8 loss pulse width", int'(xfer_lost), 0);
    run_xfer(5, 1'b1, 1'b1, 0, "R8 R4 new config");

    // R9 stop while busy
    write_cfg(8'h03);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (29) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(!busy && scl_o && !done, "R9 stop abort", int'(busy), 0);
    repeat (5) @(negedge clk);
    check(!done && !xfer_lost && scl_o, "R9 quiet after stop", int'(done), 0);
    run_xfer(3, 1'b0, 1'b0, 0, "R9 R2 after stop");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule